// File: doc/BRIEF.md
# Hash-Partitioned Row Dispatcher

This block sits at the front of a partitioned hash join. Four producer channels deliver rows, each made of a join key, a payload and a hash value computed upstream. The dispatcher sends every row to one of eight processing units. Each unit works on a private memory bank, so the partitions never compete for storage. The target unit is taken from the top three bits of the row's hash.

The routing is a 4-to-8 crossbar. Each output has a round-robin arbiter that picks one requesting channel per cycle and a small queue in front of its output stream. A channel that loses arbitration, or whose target queue is full, holds its row until it is accepted. No row is dropped, duplicated or reordered within its channel. Each input channel signals, on a separate flag, that its stream has ended. Once all four channels have ended and every queue has drained, end-of-stream is raised on all eight outputs.

Top module: `hash_row_dispatcher`

## Requirements
- R1: A row whose hash has top bits `in_hash[HASH_W-1 -: 3]` equal to u appears only on output u, exactly once.
- R2: Each output accepts at most one row per cycle. Among the channels that request it, the winner is the first one found counting upward (wrapping) from a pointer. The pointer is 0 after reset and moves to the winner's index plus one after each grant.
- R3: `in_ready[c]` is high only in a cycle in which `in_valid[c]` is high and channel c has been granted. A channel that is not granted keeps its row offered.
- R4: Each output queue holds `DEPTH` rows. A row is accepted only when the queue's occupancy before the clock edge is below `DEPTH`. This holds even when a row leaves that queue in the same cycle.
- R5: `out_valid[u]` is high exactly when queue u is not empty. While `out_ready[u]` is low, the presented row stays unchanged.
- R6: Rows from one channel that go to the same unit leave in the order they were accepted, and the queue presents the oldest row first.
- R7: `out_eos` is either all zeros or all ones. It is all ones once every channel has raised `in_eos` (latched) and all queues are empty. `out_valid` is all zeros while it is high, and it stays high after that.
- R8: While `rst` is high, and in the cycle after it, `out_valid` and `out_eos` are all zeros.
- R9: Every accepted row is delivered, with no loss and no duplication, across any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | IN_CH | Row offered on each channel |
| in_ready | output | IN_CH | Row accepted on each channel this cycle |
| in_key | input | IN_CH*KEY_W | Join keys, channel c at bits c*KEY_W |
| in_pay | input | IN_CH*PAY_W | Payloads, channel c at bits c*PAY_W |
| in_hash | input | IN_CH*HASH_W | Hash values, channel c at bits c*HASH_W |
| in_eos | input | IN_CH | Channel has no further rows (latched) |
| out_valid | output | OUT_CH | Row presented to each unit |
| out_ready | input | OUT_CH | Unit takes the presented row |
| out_key | output | OUT_CH*KEY_W | Key presented to each unit |
| out_pay | output | OUT_CH*PAY_W | Payload presented to each unit |
| out_eos | output | OUT_CH | End-of-stream, same on every unit |

## Verification
Some rules are checked on every cycle: a ready is never given without a valid, at most one channel is granted per destination unit, a stalled output keeps its row, end-of-stream is uniform across the units, comes with no valid rows and stays high, and the outputs are quiet after reset. Other properties need the bench's model to show them: that the arbiter picks channels in the right rotation, that a full queue refuses rows even while it drains, that order within each channel is kept, and that every row reaches exactly the unit its hash bits name, once.

// File: rtl/hdisp_pkg.sv
package hdisp_pkg;
    localparam int unsigned KEY_W = 16;
    localparam int unsigned PAY_W = 16;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [PAY_W-1:0] pay;
    } row_t;

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/hdisp_rr_arb.sv
module hdisp_rr_arb #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         en,
    output logic [N-1:0] gnt
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          any;

    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= int'(N)) idx = idx - int'(N);
            if (!any && en && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                any      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (any) ptr <= IW'(hdisp_pkg::wrap_inc(int'(win), N));
    end
endmodule

// File: rtl/hdisp_fifo.sv
module hdisp_fifo
    import hdisp_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  row_t din,
    output logic full,
    input  logic pop,
    output row_t dout,
    output logic empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    row_t          mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
            end
            if (do_pop) rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hash_row_dispatcher.sv
module hash_row_dispatcher
    import hdisp_pkg::*;
#(
    parameter int unsigned IN_CH  = 4,
    parameter int unsigned OUT_CH = 8,
    parameter int unsigned HASH_W = 16,
    parameter int unsigned DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IN_CH-1:0]        in_valid,
    output logic [IN_CH-1:0]        in_ready,
    input  logic [IN_CH*KEY_W-1:0]  in_key,
    input  logic [IN_CH*PAY_W-1:0]  in_pay,
    input  logic [IN_CH*HASH_W-1:0] in_hash,
    input  logic [IN_CH-1:0]        in_eos,
    output logic [OUT_CH-1:0]       out_valid,
    input  logic [OUT_CH-1:0]       out_ready,
    output logic [OUT_CH*KEY_W-1:0] out_key,
    output logic [OUT_CH*PAY_W-1:0] out_pay,
    output logic [OUT_CH-1:0]       out_eos
);
    localparam int unsigned SEL_W = $clog2(OUT_CH);

    row_t             in_row [IN_CH];
    logic [SEL_W-1:0] dest   [IN_CH];
    logic [IN_CH-1:0] gnt    [OUT_CH];
    logic [OUT_CH-1:0] q_empty;
    logic [IN_CH-1:0]  done_q;

    always_comb begin
        for (int c = 0; c < int'(IN_CH); c++) begin
            in_row[c].key = in_key[c*KEY_W +: KEY_W];
            in_row[c].pay = in_pay[c*PAY_W +: PAY_W];
            dest[c]       = in_hash[c*HASH_W + HASH_W - SEL_W +: SEL_W];
        end
    end

    for (genvar u = 0; u < int'(OUT_CH); u++) begin : g_unit
        logic [IN_CH-1:0] req;
        logic             q_full;
        row_t             push_row;
        row_t             head;

        always_comb begin
            for (int c = 0; c < int'(IN_CH); c++)
                req[c] = in_valid[c] && (dest[c] == SEL_W'(u));
        end

        hdisp_rr_arb #(.N(IN_CH)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req),
            .en  (!q_full),
            .gnt (gnt[u])
        );

        always_comb begin
            push_row = '0;
            for (int c = 0; c < int'(IN_CH); c++)
                if (gnt[u][c]) push_row = row_t'(push_row | in_row[c]);
        end

        hdisp_fifo #(.DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (|gnt[u]),
            .din   (push_row),
            .full  (q_full),
            .pop   (out_ready[u]),
            .dout  (head),
            .empty (q_empty[u])
        );

        assign out_valid[u]                = !q_empty[u];
        assign out_key[u*KEY_W +: KEY_W]   = head.key;
        assign out_pay[u*PAY_W +: PAY_W]   = head.pay;
    end

    always_comb begin
        in_ready = '0;
        for (int u = 0; u < int'(OUT_CH); u++) in_ready = in_ready | gnt[u];
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= '0;
        else     done_q <= done_q | in_eos;
    end

    assign out_eos = {OUT_CH{(&done_q) && (&q_empty)}};
endmodule

// File: rtl/hdisp_chk.sv
module hdisp_chk
    import hdisp_pkg::*;
#(
    parameter int unsigned IN_CH  = 4,
    parameter int unsigned OUT_CH = 8,
    parameter int unsigned HASH_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [IN_CH-1:0]        in_valid,
    input logic [IN_CH-1:0]        in_ready,
    input logic [IN_CH*HASH_W-1:0] in_hash,
    input logic [OUT_CH-1:0]       out_valid,
    input logic [OUT_CH-1:0]       out_ready,
    input logic [OUT_CH*KEY_W-1:0] out_key,
    input logic [OUT_CH*PAY_W-1:0] out_pay,
    input logic [OUT_CH-1:0]       out_eos
);
    localparam int unsigned SEL_W = $clog2(OUT_CH);

    // R3
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready & ~in_valid) == '0);

    for (genvar u = 0; u < int'(OUT_CH); u++) begin : g_u
        logic [IN_CH-1:0] aim;
        always_comb begin
            for (int c = 0; c < int'(IN_CH); c++)
                aim[c] = (in_hash[c*HASH_W + HASH_W - SEL_W +: SEL_W] == SEL_W'(u));
        end

        // R2
        one_grant_per_unit_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(in_ready & aim) <= 1);

        // R5
        stalled_row_held_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid[u] && !out_ready[u]) |=>
                (out_valid[u] && $stable(out_key[u*KEY_W +: KEY_W])
                              && $stable(out_pay[u*PAY_W +: PAY_W])));
    end

    // R7
    eos_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (out_eos == '0) || (&out_eos));

    // R7
    eos_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_eos[0] |-> (out_valid == '0));

    // R7
    eos_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        out_eos[0] |=> out_eos[0]);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && out_eos == '0));
endmodule

bind hash_row_dispatcher hdisp_chk #(
    .IN_CH (IN_CH),
    .OUT_CH(OUT_CH),
    .HASH_W(HASH_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_hash  (in_hash),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_key  (out_key),
    .out_pay  (out_pay),
    .out_eos  (out_eos)
);

// File: tb/hash_row_dispatcher_test.sv
module hash_row_dispatcher_test;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;
    localparam int NO = 8;
    localparam int HW = 16;
    localparam int KW = 16;
    localparam int PW = 16;
    localparam int DEPTH = 4;
    localparam int ROWS = 40;
    localparam int MAX_CYC = 20000;

    typedef struct {
        logic [KW-1:0] key;
        logic [PW-1:0] pay;
    } mrow_t;

    logic             clk = 1'b0;
    logic             rst;
    logic [NI-1:0]    in_valid, in_ready, in_eos;
    logic [NI*KW-1:0] in_key;
    logic [NI*PW-1:0] in_pay;
    logic [NI*HW-1:0] in_hash;
    logic [NO-1:0]    out_valid, out_ready, out_eos;
    logic [NO*KW-1:0] out_key;
    logic [NO*PW-1:0] out_pay;

    hash_row_dispatcher #(.IN_CH(NI), .OUT_CH(NO), .HASH_W(HW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .in_pay(in_pay), .in_hash(in_hash), .in_eos(in_eos),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_key(out_key), .out_pay(out_pay), .out_eos(out_eos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    logic [KW-1:0] rkey  [NI][ROWS];
    logic [PW-1:0] rpay  [NI][ROWS];
    logic [HW-1:0] rhash [NI][ROWS];
    int            seen  [NI][ROWS];
    int            nxt   [NI];
    bit            hold  [NI];
    bit            mdone [NI];
    int            ptr   [NO];
    int            mgnt  [NO];
    mrow_t         mq    [NO][$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_eos();
        bit e = 1'b1;
        for (int c = 0; c < NI; c++) e &= mdone[c];
        for (int u = 0; u < NO; u++) e &= (mq[u].size() == 0);
        return e;
    endfunction

    task automatic model_grant();
        for (int u = 0; u < NO; u++) begin
            mgnt[u] = -1;
            if (mq[u].size() < DEPTH) begin
                for (int k = 0; k < NI; k++) begin
                    int c;
                    c = (ptr[u] + k) % NI;
                    if (mgnt[u] < 0 && in_valid[c] && int'(in_hash[c*HW+HW-3 +: 3]) == u)
                        mgnt[u] = c;
                end
            end
        end
    endtask

    initial begin
        int  eos_run;
        bit  finished;
        logic [NI-1:0] exp_ready;
        logic [NO-1:0] exp_valid;

        rst = 1'b1;
        in_valid = '0; in_eos = '0; in_key = '0; in_pay = '0; in_hash = '0;
        out_ready = '0;
        for (int c = 0; c < NI; c++) begin
            nxt[c] = 0; hold[c] = 1'b0; mdone[c] = 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                logic [12:0] low;
                logic [2:0]  top;
                low = 13'($urandom);
                top = 3'($urandom);
                if (r < 10)       top = 3'd3;
                else if (r == 10) top = 3'd7;
                else if (r == 11) top = 3'd0;
                rkey[c][r]  = {2'(c), 14'(r)};
                rpay[c][r]  = 16'($urandom);
                rhash[c][r] = {top, low};
                seen[c][r]  = 0;
            end
        end
        for (int u = 0; u < NO; u++) ptr[u] = 0;

        repeat (3) @(negedge clk);
        // R8: outputs quiet under reset
        chk(out_valid == '0, "R8", "out_valid in reset", 64'(out_valid), 0);
        chk(out_eos == '0, "R8", "out_eos in reset", 64'(out_eos), 0);
        rst = 1'b0;

        eos_run = 0;
        finished = 1'b0;
        for (int cyc = 0; cyc < MAX_CYC && !finished; cyc++) begin
            @(negedge clk);
            for (int c = 0; c < NI; c++) begin
                if (!hold[c]) begin
                    in_valid[c] = 1'b0;
                    if (nxt[c] < ROWS && ($urandom % 4) != 0) begin
                        hold[c] = 1'b1;
                        in_valid[c] = 1'b1;
                        in_key[c*KW +: KW]  = rkey[c][nxt[c]];
                        in_pay[c*PW +: PW]  = rpay[c][nxt[c]];
                        in_hash[c*HW +: HW] = rhash[c][nxt[c]];
                    end
                    if (nxt[c] >= ROWS && ($urandom % 3) == 0) in_eos[c] = 1'b1;
                end
            end
            for (int u = 0; u < NO; u++)
                out_ready[u] = (cyc < 60) ? 1'b0 : (($urandom % 10) < 7);
            #1;
            model_grant();
            exp_ready = '0;
            for (int u = 0; u < NO; u++) if (mgnt[u] >= 0) exp_ready[mgnt[u]] = 1'b1;
            for (int u = 0; u < NO; u++) exp_valid[u] = (mq[u].size() > 0);

            // R2: arbitration and grant per output
            chk(in_ready == exp_ready, "R2", "in_ready", 64'(in_ready), 64'(exp_ready));
            // R3: no ready without valid
            chk((in_ready & ~in_valid) == '0, "R3", "ready without valid",
                64'(in_ready & ~in_valid), 0);
            // R5: valid follows queue occupancy
            chk(out_valid == exp_valid, "R5", "out_valid", 64'(out_valid), 64'(exp_valid));
            for (int u = 0; u < NO; u++) begin
                if (mq[u].size() > 0) begin
                    // R6: oldest row presented first
                    chk(out_key[u*KW +: KW] == mq[u][0].key, "R6", "out_key",
                        64'(out_key[u*KW +: KW]), 64'(mq[u][0].key));
                    chk(out_pay[u*PW +: PW] == mq[u][0].pay, "R6", "out_pay",
                        64'(out_pay[u*PW +: PW]), 64'(mq[u][0].pay));
                end
            end
            // R7: end-of-stream after all inputs end and queues drain
            chk(out_eos == (model_eos() ? {NO{1'b1}} : '0), "R7", "out_eos",
                64'(out_eos), model_eos() ? 64'hFF : 0);
            if (cyc == 59) begin
                // R4: full queue for unit 3 refuses rows
                chk(out_valid[3] == 1'b1, "R4", "unit 3 holds rows", 64'(out_valid[3]), 1);
                for (int c = 0; c < NI; c++)
                    if (in_valid[c] && in_hash[c*HW+HW-3 +: 3] == 3'd3)
                        chk(in_ready[c] == 1'b0, "R4", "accept into full queue",
                            64'(in_ready[c]), 0);
            end

            for (int u = 0; u < NO; u++) begin
                if (mq[u].size() > 0 && out_ready[u]) begin
                    mrow_t m;
                    int c, r;
                    m = mq[u].pop_front();
                    c = int'(m.key[15:14]);
                    r = int'(m.key[13:0]);
                    // R1: delivered once, on the unit named by its hash top bits
                    chk(seen[c][r] == 0 && int'(rhash[c][r][15:13]) == u, "R1",
                        "delivery unit", 64'(u), 64'(rhash[c][r][15:13]));
                    seen[c][r]++;
                end
            end
            for (int u = 0; u < NO; u++) begin
                if (mgnt[u] >= 0) begin
                    mrow_t m;
                    int c;
                    c = mgnt[u];
                    m.key = in_key[c*KW +: KW];
                    m.pay = in_pay[c*PW +: PW];
                    mq[u].push_back(m);
                    ptr[u] = (c + 1) % NI;
                    hold[c] = 1'b0;
                    nxt[c]++;
                end
            end
            for (int c = 0; c < NI; c++) if (in_eos[c]) mdone[c] = 1'b1;
            if (model_eos()) eos_run++;
            if (eos_run > 5) finished = 1'b1;
        end

        if (!finished) chk(1'b0, "R9", "watchdog expired", 0, 1);
        for (int c = 0; c < NI; c++) begin
            int miss;
            miss = 0;
            for (int r = 0; r < ROWS; r++) if (seen[c][r] != 1) miss++;
            // R9: no loss or duplication per channel
            chk(miss == 0, "R9", "rows not delivered once", 64'(miss), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule